// File: doc/BRIEF.md
# Bit-Serial Byte ALU

This block computes one byte-wide arithmetic or logic result with a single one-bit datapath slice that is reused on successive clocks. An accumulator register holds the implicit first operand and receives the result. The second operand is loaded in parallel when an operation starts and is then shifted out toward the slice, lowest bit first. Each result bit enters the accumulator at its top end as the accumulator shifts right, so after the last bit the result sits in place, least significant bit at position 0.

A carry flip-flop links one bit-cycle to the next. Subtraction is formed by inverting the second operand bits and presetting that flip-flop to one. Running OR and XOR registers collect the zero and parity information while the bits go by. When the final bit is done the block latches four condition flags and gives a one-cycle completion strobe. There is no multiply or divide. The accumulator can be written in parallel whenever the block is idle.

Top module: `bitser_alu`

## Requirements
- R1: After reset busy_o, done_o, acc_o and all four flags are 0.
- R2: While idle, acc_load_i writes acc_din_i into acc_o on the next clock. When start_i is also high, start_i wins and the load is dropped. While busy, acc_load_i is ignored.
- R3: start_i accepted while idle makes busy_o high for exactly DATA_W cycles, starting with the cycle after the start edge. done_o is high for one cycle only: the cycle right after busy_o's last cycle.
- R4: start_i while busy_o is high is ignored. The running operation keeps its length, opcode and operand.
- R5: op_i = 0 (add): the result is acc + opb modulo 2^DATA_W, and carry_o is the carry out of the top bit.
- R6: op_i = 1 (subtract): the result is acc - opb modulo 2^DATA_W, and carry_o is 1 exactly when acc < opb (borrow).
- R7: op_i = 2 gives bitwise AND and op_i = 3 gives bitwise OR. Both clear carry_o.
- R8: At completion zero_o is 1 exactly when the result is 0, sign_o equals result bit DATA_W-1, and parity_o is 1 exactly when the result has an even number of 1 bits.
- R9: Operands go least significant bit first. After k busy cycles, acc_o holds result bits k-1..0 in its top k positions and the unprocessed accumulator bits below them.
- R10: The flags change only at completion and keep their values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| op_i | input | 2 | 0 add, 1 subtract, 2 AND, 3 OR |
| opb_i | input | DATA_W | Second operand, captured at start |
| acc_load_i | input | 1 | Parallel accumulator write (idle only) |
| acc_din_i | input | DATA_W | Accumulator write data |
| busy_o | output | 1 | Serial operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| acc_o | output | DATA_W | Accumulator contents |
| carry_o | output | 1 | Carry (add) or borrow (subtract), 0 for logic |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result top bit |
| parity_o | output | 1 | Result has an even count of ones |

## Verification
The accumulator is visible on every cycle, so a fault in the bit slice, the carry flip-flop or the shift direction shows on acc_o in the very busy cycle where it first occurs. The bench compares acc_o against a reference on every clock. A bit-counter fault shows up as a busy window of the wrong length, or as done_o appearing in the wrong cycle. A fault in the running zero or parity registers, or in borrow inversion, stays hidden until completion and then shows on the flag outputs in the done_o cycle. A start or load that leaks through while busy corrupts acc_o one cycle later.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_OR  = 2'd3
   } alu_op_e;

   typedef struct packed {
      logic carry;
      logic zero;
      logic sign;
      logic parity;
   } alu_flags_t;

   function automatic logic op_is_logic(alu_op_e op);
      return (op == OP_AND) || (op == OP_OR);
   endfunction

endpackage

// File: rtl/bsalu_slice.sv
module bsalu_slice
   import bsalu_pkg::*;
#(
   parameter int ADDER_STYLE = 0
) (
   input  alu_op_e op_i,
   input  logic    a_i,
   input  logic    b_i,
   input  logic    cin_i,
   output logic    r_o,
   output logic    cout_o
);

   logic b_eff;
   logic sum_bit;
   logic sum_cout;

   assign b_eff = (op_i == OP_SUB) ? ~b_i : b_i;

   generate
      if (ADDER_STYLE == 0) begin : g_gate
         assign sum_bit  = a_i ^ b_eff ^ cin_i;
         assign sum_cout = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
      end else if (ADDER_STYLE == 1) begin : g_arith
         logic [1:0] tot;
         assign tot      = {1'b0, a_i} + {1'b0, b_eff} + {1'b0, cin_i};
         assign sum_bit  = tot[0];
         assign sum_cout = tot[1];
      end else begin : g_bad_style
         $error("bsalu_slice: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_ADD, OP_SUB: begin
            r_o    = sum_bit;
            cout_o = sum_cout;
         end
         OP_AND: begin
            r_o    = a_i & b_i;
            cout_o = 1'b0;
         end
         default: begin
            r_o    = a_i | b_i;
            cout_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/bsalu_seq.sv
module bsalu_seq #(
   parameter int DATA_W = 8,
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic accept_o,
   output logic busy_o,
   output logic last_o,
   output logic done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   assign accept_o = start_i & ~busy_q;
   assign last_o   = busy_q & (cnt_q == CNT_LAST);
   assign busy_o   = busy_q;
   assign done_o   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            if (cnt_q == CNT_LAST) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   // R3: counter advances by one on every busy cycle before the last
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last_o |=> busy_q && (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R3: the last bit-cycle is followed by the done strobe and idle
   a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> done_q && !busy_q);

   // R3: done is a single-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R4: a start during an operation does not restart the counter
   a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && start_i && !last_o |=> busy_q && (cnt_q != '0));

endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags
   import bsalu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_i,
   input  alu_op_e    start_op_i,
   input  logic       step_i,
   input  logic       last_i,
   input  alu_op_e    op_i,
   input  logic       res_bit_i,
   input  logic       cout_i,
   output logic       cin_o,
   output alu_flags_t flags_o
);

   logic       carry_q;
   logic       run_or_q;
   logic       run_x_q;
   alu_flags_t flags_q;
   logic       fin_carry;

   assign cin_o   = carry_q;
   assign flags_o = flags_q;

   always_comb begin
      unique case (op_i)
         OP_ADD:  fin_carry = cout_i;
         OP_SUB:  fin_carry = ~cout_i;
         default: fin_carry = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q  <= 1'b0;
         run_or_q <= 1'b0;
         run_x_q  <= 1'b0;
         flags_q  <= '0;
      end else begin
         if (accept_i) begin
            carry_q  <= (start_op_i == OP_SUB);
            run_or_q <= 1'b0;
            run_x_q  <= 1'b0;
         end else if (step_i) begin
            carry_q  <= cout_i;
            run_or_q <= run_or_q | res_bit_i;
            run_x_q  <= run_x_q ^ res_bit_i;
         end
         if (last_i) begin
            flags_q.carry  <= fin_carry;
            flags_q.zero   <= ~(run_or_q | res_bit_i);
            flags_q.sign   <= res_bit_i;
            flags_q.parity <= ~(run_x_q ^ res_bit_i);
         end
      end
   end

   // R10: flags only move at the end of an operation
   a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !last_i |=> $stable(flags_q));

   // R6: subtract starts with the carry flip-flop set
   a_r6_sub_preset: assert property (@(posedge clk) disable iff (!rst_n)
      accept_i && (start_op_i == OP_SUB) |=> carry_q);

endmodule

// File: rtl/bitser_alu.sv
module bitser_alu
   import bsalu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic              acc_load_i,
   input  logic [DATA_W-1:0] acc_din_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              carry_o,
   output logic              zero_o,
   output logic              sign_o,
   output logic              parity_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bitser_alu: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] opb_q;
   alu_op_e           op_q;
   alu_op_e           op_in;
   logic              accept;
   logic              busy;
   logic              last;
   logic              done;
   logic              res_bit;
   logic              cout;
   logic              cin;
   alu_flags_t        flags;

   assign op_in = alu_op_e'(op_i);

   bsalu_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy),
      .last_o   (last),
      .done_o   (done)
   );

   bsalu_slice #(.ADDER_STYLE(ADDER_STYLE)) u_slice (
      .op_i   (op_q),
      .a_i    (acc_q[0]),
      .b_i    (opb_q[0]),
      .cin_i  (cin),
      .r_o    (res_bit),
      .cout_o (cout)
   );

   bsalu_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .start_op_i (op_in),
      .step_i     (busy),
      .last_i     (last),
      .op_i       (op_q),
      .res_bit_i  (res_bit),
      .cout_i     (cout),
      .cin_o      (cin),
      .flags_o    (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         opb_q <= '0;
         op_q  <= OP_ADD;
      end else if (busy) begin
         acc_q <= {res_bit, acc_q[DATA_W-1:1]};
         opb_q <= {1'b0, opb_q[DATA_W-1:1]};
      end else if (accept) begin
         opb_q <= opb_i;
         op_q  <= op_in;
      end else if (acc_load_i) begin
         acc_q <= acc_din_i;
      end
   end

   assign busy_o   = busy;
   assign done_o   = done;
   assign acc_o    = acc_q;
   assign carry_o  = flags.carry;
   assign zero_o   = flags.zero;
   assign sign_o   = flags.sign;
   assign parity_o = flags.parity;

   // R2: idle accumulator changes only through a parallel load
   a_r2_acc_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !acc_load_i |=> $stable(acc_q));

   // R7: logic operations leave the carry flag clear
   a_r7_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      done && op_is_logic(op_q) |-> !carry_o);

   // R8: sign flag mirrors the top result bit
   a_r8_sign_msb: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sign_o == acc_q[DATA_W-1]);

   // R8: zero flag agrees with the finished result
   a_r8_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> zero_o == (acc_q == '0));

   // R8: parity flag agrees with the finished result
   a_r8_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> parity_o == ~(^acc_q));

endmodule

// File: tb/bitser_alu_test.sv
module bitser_alu_test;

   localparam int W       = 8;
   localparam int CLK_PER = 10;
   localparam int MASK    = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = 2'd0;
   logic [W-1:0] opb_i = '0;
   logic         acc_load_i = 1'b0;
   logic [W-1:0] acc_din_i = '0;
   logic         busy_o, done_o, carry_o, zero_o, sign_o, parity_o;
   logic [W-1:0] acc_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit chk_en = 1'b0;

   // reference model state
   int m_acc, m_busy, m_done, m_cnt, m_res, m_cy;
   int m_c, m_z, m_s, m_p;

   always #(CLK_PER/2) clk = ~clk;

   bitser_alu #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .opb_i(opb_i), .acc_load_i(acc_load_i), .acc_din_i(acc_din_i),
      .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o),
      .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o), .parity_o(parity_o)
   );

   function automatic int ones(int v);
      int n = 0;
      for (int i = 0; i < W; i++) n += (v >> i) & 1;
      return n;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_res = 0; m_cy = 0;
         m_c = 0; m_z = 0; m_s = 0; m_p = 0;
      end else begin
         m_done = 0;
         if (m_busy != 0) begin
            m_acc = (m_acc >> 1) | (((m_res >> m_cnt) & 1) << (W - 1));
            m_cnt++;
            if (m_cnt == W) begin
               m_busy = 0; m_done = 1;
               m_c = m_cy; m_z = (m_res == 0); m_s = (m_res >> (W - 1)) & 1;
               m_p = ((ones(m_res) % 2) == 0);
            end
         end else if (start_i) begin
            m_busy = 1; m_cnt = 0;
            case (op_i)
               2'd0: begin m_res = (m_acc + int'(opb_i)) & MASK; m_cy = (m_acc + int'(opb_i)) > MASK; end
               2'd1: begin m_res = (m_acc - int'(opb_i)) & MASK; m_cy = m_acc < int'(opb_i); end
               2'd2: begin m_res = m_acc & int'(opb_i); m_cy = 0; end
               default: begin m_res = m_acc | int'(opb_i); m_cy = 0; end
            endcase
         end else if (acc_load_i) begin
            m_acc = int'(acc_din_i);
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R3 timing, R9 bit order, R10 flag hold)
   always @(negedge clk) begin
      if (chk_en) begin
         check("R3", "busy", int'(busy_o), m_busy);
         check("R3", "done", int'(done_o), m_done);
         check("R9", "acc", int'(acc_o), m_acc);
         check("R10", "flags", int'({carry_o, zero_o, sign_o, parity_o}),
               (m_c << 3) | (m_z << 2) | (m_s << 1) | m_p);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic load_acc(int v);
      tick(); acc_load_i = 1'b1; acc_din_i = W'(v);
      tick(); acc_load_i = 1'b0;
   endtask

   // run one operation and check the finished result independently
   task automatic run_op(string req, int op, int a, int b);
      int res, cy, n;
      load_acc(a);
      tick(); start_i = 1'b1; op_i = 2'(op); opb_i = W'(b);
      tick(); start_i = 1'b0;
      n = 0;
      while (!done_o && n < 3 * W) begin @(negedge clk); n++; end
      case (op)
         0: begin res = (a + b) & MASK; cy = (a + b) > MASK; end
         1: begin res = (a - b) & MASK; cy = a < b; end
         2: begin res = a & b; cy = 0; end
         default: begin res = a | b; cy = 0; end
      endcase
      check(req, "done seen", int'(done_o), 1);
      check(req, "result", int'(acc_o), res);
      check(req, "carry", int'(carry_o), cy);
      check("R8", "zero", int'(zero_o), int'(res == 0));
      check("R8", "sign", int'(sign_o), (res >> (W - 1)) & 1);
      check("R8", "parity", int'(parity_o), int'((ones(res) % 2) == 0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", int'(busy_o), 0);
      check("R1", "done", int'(done_o), 0);
      check("R1", "acc", int'(acc_o), 0);
      check("R1", "flags", int'({carry_o, zero_o, sign_o, parity_o}), 0);
      #1 rst_n = 1'b1;
      chk_en = 1'b1;

      // R2: idle load
      load_acc(8'hA5);
      check("R2", "load", int'(acc_o), 8'hA5);

      run_op("R5", 0, 8'h5A, 8'h3C);
      run_op("R5", 0, 8'hFF, 8'h01);
      run_op("R6", 1, 8'h10, 8'h20);
      run_op("R6", 1, 8'h33, 8'h33);
      run_op("R6", 1, 8'h80, 8'h01);
      run_op("R7", 2, 8'hF0, 8'h3C);
      run_op("R7", 3, 8'h0F, 8'h30);
      run_op("R7", 2, 8'h0F, 8'hF0);

      // R4: start and R2: load while busy are ignored
      load_acc(8'h21);
      tick(); start_i = 1'b1; op_i = 2'd0; opb_i = 8'h11;
      tick(); start_i = 1'b0;
      tick(); start_i = 1'b1; op_i = 2'd3; opb_i = 8'hFF;
      acc_load_i = 1'b1; acc_din_i = 8'h77;
      tick(); start_i = 1'b0; acc_load_i = 1'b0;
      repeat (W) @(negedge clk);
      check("R4", "result after ignored start", int'(acc_o), 8'h32);
      check("R4", "busy ended", int'(busy_o), 0);

      // R2: start wins over a simultaneous load
      tick(); start_i = 1'b1; acc_load_i = 1'b1; op_i = 2'd0; opb_i = 8'h01; acc_din_i = 8'h00;
      tick(); start_i = 1'b0; acc_load_i = 1'b0;
      repeat (W) @(negedge clk);
      check("R2", "start over load", int'(acc_o), 8'h33);

      // R3: back-to-back start in the done cycle
      check("R3", "done cycle", int'(done_o), 1);
      #1 start_i = 1'b1; op_i = 2'd1; opb_i = 8'h03;
      tick(); start_i = 1'b0;
      repeat (W) @(negedge clk);
      check("R3", "chained result", int'(acc_o), 8'h30);

      // mixed operands, model compared on every clock
      for (int i = 0; i < 300; i++)
         run_op("R5", int'($urandom_range(0, 3)), int'($urandom_range(0, MASK)),
                int'($urandom_range(0, MASK)));

      repeat (3) tick();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule